// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit

This block is the integer multiply and divide engine of a processor datapath. It takes one request at a time. A request is a one-cycle `start` with an operation select, a signed/unsigned select, a 32-bit destination operand, a 16-bit source operand and the current 16-bit status word. A multiply forms the full 32-bit product of the low halves of the two operands. A divide splits a 32-bit dividend by a 16-bit divisor and packs the quotient and the remainder into one 32-bit word.

Both operations run bit-serially on operand magnitudes. The multiply takes one shift-add step per clock. The divide takes one restoring step per clock, and a final cycle restores the signs. Each request ends with a one-cycle `done` pulse, which carries the result, a write-back strobe, the updated status word and a divide-by-zero trap flag. When a quotient does not fit in 16 bits, the destination is handed back untouched. A zero divisor does the same and raises the trap.

Top module: `muldiv_seq`

## Requirements
- R1: A multiply uses only `dst[15:0]` and `src[15:0]` and returns their full 32-bit product. Both operands are two's complement when `is_signed`=1 and unsigned otherwise. `wr_en`=1 and `trap`=0.
- R2: Status bit positions are C=0, V=1, Z=2, N=3, X=4. After a multiply: N = product bit 31, Z = (product == 0), V=0, C=0, X and `sr_in[15:8]` are copied, and bits 7..5 are 0.
- R3: A divide with a non-zero divisor whose quotient fits returns the quotient in `result[15:0]` and the remainder in `result[31:16]`, with `wr_en`=1. A signed divide truncates toward zero, and its remainder takes the sign of the dividend.
- R4: A quotient outside -32768..32767 (signed) or above 65535 (unsigned) sets V, returns `dst` unchanged and gives `wr_en`=0.
- R5: After a divide with a non-zero divisor: Z = (quotient == 0), N = bit 15 of the two's complement quotient (also on overflow), C=0, X and `sr_in[15:8]` are copied, and bits 7..5 are 0.
- R6: A zero divisor (`src`==0) gives `trap`=1, clears N, Z, V and C, keeps X and `sr_in[15:8]`, returns `dst` unchanged and gives `wr_en`=0.
- R7: `done` is high in the cycle after the 17th rising edge following the edge that accepts `start` for a multiply. It is the 33rd edge for a divide with a non-zero divisor and the 1st edge for a zero divisor.
- R8: `done` lasts exactly one cycle. `wr_en` and `trap` are high only while `done` is high.
- R9: `start` is ignored while a request is in progress. Operands applied then do not change the result.
- R10: After reset, `done`, `wr_en`, `trap`, `result` and `sr_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| is_signed | input | 1 | 1 = two's complement operands |
| dst | input | 32 | Destination operand / dividend |
| src | input | 16 | Source operand / divisor |
| sr_in | input | 16 | Incoming status word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product, packed quotient/remainder, or unchanged destination |
| wr_en | output | 1 | Destination should be written back |
| sr_out | output | 16 | Updated status word |
| trap | output | 1 | Divide-by-zero trap |

## Verification
A wrong step counter or state register shows at the ports as `done` arriving early, late or twice. The bench checks `done` on every clock of a request, so such an error is seen in the very cycle it occurs. A fault in the partial remainder or in the accumulator only appears in the final word. Directed divides near the overflow limits and with mixed operand signs make such faults change `result`, V or N on the request's own `done` cycle. Applying operands while the unit is busy exposes any re-capture of inputs at that same completion.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_t;

  localparam int FLG_C       = 0;
  localparam int FLG_V       = 1;
  localparam int FLG_Z       = 2;
  localparam int FLG_N       = 3;
  localparam int FLG_X       = 4;
  localparam int FLG_KEEP_LO = 8;
endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_mag,
  input  logic [W-1:0]   b_mag,
  output logic [2*W-1:0] prod
);
  localparam int DW = 2 * W;

  logic [DW-1:0] acc_q;
  logic [DW-1:0] mcand_q;
  logic [W-1:0]  mplr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mcand_q <= {{W{1'b0}}, a_mag};
      mplr_q  <= b_mag;
    end else if (step) begin
      if (mplr_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q <= {mcand_q[DW-2:0], 1'b0};
      mplr_q  <= {1'b0, mplr_q[W-1:1]};
    end
  end

  assign prod = acc_q;

  // R1: a freshly loaded multiply starts from an empty accumulator
  a_r1_acc_cleared: assert property (@(posedge clk) disable iff (rst)
    load |=> (acc_q == '0));
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dd_mag,
  input  logic [W-1:0]   dv_mag,
  output logic [2*W-1:0] quo,
  output logic [W-1:0]   rem
);
  localparam int DW = 2 * W;

  logic [DW-1:0] quo_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  dv_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[DW-1]};
    trial   = shifted - {1'b0, dv_q};
    fits    = ~trial[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0;
      rem_q <= '0;
      dv_q  <= '0;
    end else if (load) begin
      quo_q <= dd_mag;
      rem_q <= '0;
      dv_q  <= dv_mag;
    end else if (step) begin
      if (fits) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[DW-2:0], 1'b0};
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

  // R3: the partial remainder always stays below a non-zero divisor
  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
    (dv_q != '0) |-> (rem_q < dv_q));
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W   = 16,
  parameter int SRW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           op_div,
  input  logic           is_signed,
  input  logic [2*W-1:0] dst,
  input  logic [W-1:0]   src,
  input  logic [SRW-1:0] sr_in,
  output logic           done,
  output logic [2*W-1:0] result,
  output logic           wr_en,
  output logic [SRW-1:0] sr_out,
  output logic           trap
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_MUL = CW'(W - 1);
  localparam logic [CW-1:0] LAST_DIV = CW'(DW - 1);
  localparam logic [DW-1:0] LIM_POS  = {{(DW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [DW-1:0] LIM_NEG  = LIM_POS + DW'(1);

  md_state_t      state;
  logic [CW-1:0]  cnt;
  logic           op_div_q, sgn_q, neg_q, rneg_q, zdiv_q;
  logic [DW-1:0]  dst_q;
  logic [SRW-1:0] sr_q;

  logic           accept;
  logic [W-1:0]   mul_a_mag, mul_b_mag, dv_mag;
  logic [DW-1:0]  dd_mag;
  logic [DW-1:0]  prod, quo;
  logic [W-1:0]   rem;

  always_comb begin
    accept    = start && (state == ST_IDLE);
    mul_a_mag = (is_signed && dst[W-1]) ? ({W{1'b0}} - dst[W-1:0]) : dst[W-1:0];
    mul_b_mag = (is_signed && src[W-1]) ? ({W{1'b0}} - src) : src;
    dd_mag    = (is_signed && dst[DW-1]) ? ({DW{1'b0}} - dst) : dst;
    dv_mag    = mul_b_mag;
  end

  muldiv_mul_core #(.W(W)) u_mul (
    .clk   (clk),
    .rst   (rst),
    .load  (accept && !op_div),
    .step  (state == ST_RUN && !op_div_q),
    .a_mag (mul_a_mag),
    .b_mag (mul_b_mag),
    .prod  (prod)
  );

  muldiv_div_core #(.W(W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .load   (accept && op_div),
    .step   (state == ST_RUN && op_div_q),
    .dd_mag (dd_mag),
    .dv_mag (dv_mag),
    .quo    (quo),
    .rem    (rem)
  );

  // final sign fixup and flag formation
  logic [DW-1:0]  prod_s, quo_s;
  logic [W-1:0]   rem_s;
  logic           ovf;
  logic [SRW-1:0] sr_base, fin_sr;
  logic [DW-1:0]  fin_res;
  logic           fin_wr, fin_trap;
  logic           unused_sr_bits;

  assign unused_sr_bits = ^{sr_q[FLG_KEEP_LO-1:FLG_X+1], sr_q[FLG_N:FLG_C]};

  always_comb begin
    prod_s = neg_q  ? ({DW{1'b0}} - prod) : prod;
    quo_s  = neg_q  ? ({DW{1'b0}} - quo)  : quo;
    rem_s  = rneg_q ? ({W{1'b0}} - rem)   : rem;
    if (sgn_q) ovf = neg_q ? (quo > LIM_NEG) : (quo > LIM_POS);
    else       ovf = |quo[DW-1:W];

    sr_base = '0;
    sr_base[SRW-1:FLG_KEEP_LO] = sr_q[SRW-1:FLG_KEEP_LO];
    sr_base[FLG_X] = sr_q[FLG_X];

    fin_sr   = sr_base;
    fin_res  = dst_q;
    fin_wr   = 1'b0;
    fin_trap = 1'b0;
    if (!op_div_q) begin
      fin_res       = prod_s;
      fin_wr        = 1'b1;
      fin_sr[FLG_N] = prod_s[DW-1];
      fin_sr[FLG_Z] = (prod_s == '0);
    end else if (zdiv_q) begin
      fin_trap = 1'b1;
    end else begin
      fin_sr[FLG_N] = quo_s[W-1];
      fin_sr[FLG_Z] = (quo_s == '0);
      fin_sr[FLG_V] = ovf;
      if (!ovf) begin
        fin_res = {rem_s, quo_s[W-1:0]};
        fin_wr  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      op_div_q <= 1'b0;
      sgn_q    <= 1'b0;
      neg_q    <= 1'b0;
      rneg_q   <= 1'b0;
      zdiv_q   <= 1'b0;
      dst_q    <= '0;
      sr_q     <= '0;
      done     <= 1'b0;
      result   <= '0;
      wr_en    <= 1'b0;
      sr_out   <= '0;
      trap     <= 1'b0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      trap  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_div_q <= op_div;
            sgn_q    <= is_signed;
            neg_q    <= is_signed && ((op_div ? dst[DW-1] : dst[W-1]) ^ src[W-1]);
            rneg_q   <= is_signed && dst[DW-1];
            zdiv_q   <= op_div && (src == '0);
            dst_q    <= dst;
            sr_q     <= sr_in;
            cnt      <= '0;
            state    <= (op_div && (src == '0)) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + CW'(1);
          if (cnt == (op_div_q ? LAST_DIV : LAST_MUL)) state <= ST_FIN;
        end
        ST_FIN: begin
          done   <= 1'b1;
          result <= fin_res;
          wr_en  <= fin_wr;
          trap   <= fin_trap;
          sr_out <= fin_sr;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: strobes appear only alongside done
  a_r8_strobes_with_done: assert property (@(posedge clk) disable iff (rst)
    (wr_en || trap) |-> done);
  // R9: captured request is not replaced while busy
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> ($stable(dst_q) && $stable(sr_q) && $stable(op_div_q)));
  // R6: trap clears the arithmetic flags and blocks write-back
  a_r6_trap_flags: assert property (@(posedge clk) disable iff (rst)
    trap |-> (!wr_en && sr_out[FLG_N:FLG_C] == '0 && sr_out[FLG_X] == sr_q[FLG_X]));
  // R4: a refused divide sets V and hands back the destination
  a_r4_no_overflow_write: assert property (@(posedge clk) disable iff (rst)
    (done && op_div_q && !trap && !wr_en) |-> (sr_out[FLG_V] && result == dst_q));
  // R2: a multiply always writes back with V and C clear
  a_r2_mul_vc_clear: assert property (@(posedge clk) disable iff (rst)
    (done && !op_div_q) |-> (wr_en && !sr_out[FLG_V] && !sr_out[FLG_C]));
endmodule

// File: tb/muldiv_seq_tb.sv
module muldiv_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dst = '0;
  logic [15:0] src = '0;
  logic [15:0] sr_in = '0;
  logic        done, wr_en, trap;
  logic [31:0] result;
  logic [15:0] sr_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  muldiv_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div), .is_signed(is_signed),
    .dst(dst), .src(src), .sr_in(sr_in), .done(done), .result(result),
    .wr_en(wr_en), .sr_out(sr_out), .trap(trap)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_op(input bit div, input bit sg, input logic [31:0] d,
                        input logic [15:0] s, input logic [15:0] sr, input bit poke,
                        input string tag);
    longint a, b, p, dd, dv, q, r;
    logic [31:0] e_res;
    logic [15:0] e_sr;
    bit e_wr, e_trap, ovf;
    int lat;
    e_sr = {sr[15:8], 3'b000, sr[4], 4'b0000};
    e_res = d; e_wr = 0; e_trap = 0;
    if (!div) begin
      a = sg ? longint'($signed(d[15:0])) : longint'(d[15:0]);
      b = sg ? longint'($signed(s)) : longint'(s);
      p = a * b;
      e_res = p[31:0]; e_wr = 1;
      e_sr[3] = e_res[31]; e_sr[2] = (e_res == 0);
      lat = 17;
    end else if (s == 0) begin
      e_trap = 1; lat = 1;
    end else begin
      dd = sg ? longint'($signed(d)) : longint'(d);
      dv = sg ? longint'($signed(s)) : longint'(s);
      q = dd / dv; r = dd % dv;
      ovf = sg ? (q < -32768 || q > 32767) : (q > 65535);
      e_sr[3] = q[15]; e_sr[2] = (q == 0); e_sr[1] = ovf;
      if (!ovf) begin
        e_res = {r[15:0], q[15:0]}; e_wr = 1;
      end
      lat = 33;
    end
    @(negedge clk);
    op_div = div; is_signed = sg; dst = d; src = s; sr_in = sr; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k < lat) begin
        // R7 / R8: no completion or strobe before the due cycle
        chk(!done && !wr_en && !trap, {tag, " R7 early done"}, {done, wr_en, trap}, 0);
        if (poke && k == 1) begin
          // R9: new request while busy
          start = 1; dst = ~d; src = s + 16'd3; op_div = ~div; sr_in = ~sr;
        end
        if (poke && k == 2) start = 0;
      end else begin
        chk(done == 1, {tag, " R7 done on time"}, done, 1);
        chk(result == e_res, {tag, " R1/R3/R4 result"}, result, e_res);
        chk(sr_out == e_sr, {tag, " R2/R5/R6 sr_out"}, sr_out, e_sr);
        chk(wr_en == e_wr, {tag, " R4 wr_en"}, wr_en, e_wr);
        chk(trap == e_trap, {tag, " R6 trap"}, trap, e_trap);
      end
    end
    @(negedge clk);
    chk(!done && !wr_en && !trap, {tag, " R8 single pulse"}, {done, wr_en, trap}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!done && !wr_en && !trap, "R10 reset strobes", {done, wr_en, trap}, 0);
    chk(result == 0 && sr_out == 0, "R10 reset data", {result, sr_out}, 0);
    rst = 0;
    // multiply: R1, R2
    run_op(0, 0, 32'h0000_FFFF, 16'hFFFF, 16'hA51F, 0, "R1 umul max");
    run_op(0, 1, 32'h0000_FFFF, 16'hFFFF, 16'h0010, 0, "R1 smul -1*-1");
    run_op(0, 1, 32'h0000_8000, 16'h8000, 16'h00EF, 0, "R1 smul min*min");
    run_op(0, 1, 32'h0000_0003, 16'hFFFB, 16'h3300, 0, "R2 smul neg");
    run_op(0, 0, 32'hABCD_0002, 16'h0003, 16'h0000, 0, "R1 upper ignored");
    run_op(0, 1, 32'h1234_0000, 16'h7777, 16'hFFFF, 0, "R2 zero product");
    // divide: R3, R5
    run_op(1, 0, 32'd100, 16'd7, 16'h0010, 0, "R3 udiv");
    run_op(1, 1, 32'hFFFF_FF9C, 16'd7, 16'h0000, 0, "R3 sdiv neg dividend");
    run_op(1, 1, 32'd100, 16'hFFF9, 16'h00FF, 0, "R3 sdiv neg divisor");
    run_op(1, 0, 32'd5, 16'd10, 16'h8000, 0, "R5 zero quotient");
    run_op(1, 0, 32'h0000_8000, 16'd1, 16'h0000, 0, "R5 N from bit15");
    run_op(1, 1, 32'hFFFF_8000, 16'd1, 16'h0000, 0, "R4 signed min fits");
    // overflow: R4
    run_op(1, 0, 32'h0001_0000, 16'd1, 16'h0F1F, 0, "R4 unsigned ovf");
    run_op(1, 1, 32'h0000_8000, 16'd1, 16'h0000, 0, "R4 signed ovf pos");
    run_op(1, 1, 32'h8000_0000, 16'hFFFF, 16'h0013, 0, "R4 signed ovf min/-1");
    // zero divisor: R6
    run_op(1, 0, 32'hDEAD_BEEF, 16'd0, 16'hFFFF, 0, "R6 zero divisor");
    run_op(1, 1, 32'h0000_0001, 16'd0, 16'h00E0, 0, "R6 zero divisor signed");
    // busy: R9
    run_op(0, 0, 32'h0000_1234, 16'h0056, 16'h0000, 1, "R9 mul busy start");
    run_op(1, 1, 32'hFFFF_F000, 16'd33, 16'h0010, 1, "R9 div busy start");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule